// File: doc/BRIEF.md
# No-turnaround flow-through synchronous SRAM

This block models a synchronous static memory whose data bus can stay fully occupied however reads and writes are mixed. Every access is started by a load edge. At that edge the address and the read/write control are captured. A read drives the addressed word during the very next clock cycle, straight from the array with no output register. A write takes its data and byte enables one edge later. Because of that late data, a read may follow a write, or a write may follow a read, in back-to-back cycles with no idle cycle between them.

Once an access is loaded, an advance strobe steps through a four-beat burst from the loaded address. The beat order is linear or interleaved, chosen by a static mode input. A clock-hold input freezes all state. Three chip selects qualify each load. An asynchronous output-enable gates the read data drivers. The bidirectional bus is split into separate data-in, data-out and drive-enable ports, and the pad buffer is left to the integrator.

Top module: `ntsram_ft`

## Requirements
- R1: While `rst` is high at a rising edge, the access state becomes deselected and no pending write remains. After reset, `dout_en` is low, and an advance cycle (`adv_ld`=1) issued before any load also leaves it low.
- R2: When `hold` is 1 at a rising edge, every input is ignored and all state is kept. A read keeps presenting the same word. A pending write neither commits nor loses its slot, and it takes its data at the first edge where `hold` is 0.
- R3: A load edge has `hold`=0 and `adv_ld`=0. It starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load edge with any of these selects inactive is a deselect: nothing is driven and nothing is written. An advance edge that follows a deselect stays deselected.
- R4: A load edge with `wr_n`=1 starts a read. In the cycle that follows it, `dout` carries the word stored at `addr`, with no further clock edge in between.
- R5: A load edge with `wr_n`=0 starts a write. The value on `din` at that edge is ignored. The word is written from `din` and `be_n` as sampled at the next rising edge that has `hold`=0.
- R6: `be_n[i]`=0 writes bits [8i+7:8i] and leaves the other lanes unchanged. A write beat with every `be_n` bit high stores nothing, but the burst still advances to the next beat when `adv_ld` is 1.
- R7: A read with `oe_n`=1 still selects the word but leaves `dout_en` low. `oe_n` acts combinationally: the drivers turn on or off in the same cycle, with no clock edge.
- R8: With `burst_ilv`=0, advance edges step the two low address bits as (start + beat) mod 4 and keep the upper bits. After four beats the sequence wraps back to the start address.
- R9: With `burst_ilv`=1, the two low address bits of each beat are start XOR beat.
- R10: Reads and writes may alternate on consecutive load edges with no idle cycle. A read loaded at the same edge that commits a write to the same address returns the newly written data.
- R11: `dout_en` is low during write cycles and deselected cycles, whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: ignore this edge and keep all state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | Low: load a new access; high: advance the burst |
| wr_n | input | 1 | Sampled at load: low = write, high = read |
| be_n | input | LANES | Byte-lane write enables, active low, sampled with write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address, captured at load edges |
| din | input | DW | Write data, sampled one edge after the write command |
| dout | output | DW | Flow-through read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
A corrupted access state appears in the first cycle after the edge where it went wrong. The bus is driven when it should not be, or stays released during a read, so `dout_en` exposes it at once. A broken beat counter or address register puts the wrong word on `dout` in that same cycle of a burst. A missed or misplaced late write is not visible while it happens. It appears only at the next read of the affected address, one load later, which the directed tests place immediately after each write.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;

  // Number of low address bits walked by a burst.
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10
  } op_e;

  // All three selects must be in their active state.
  function automatic logic sel_all(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // Low address bits of a given beat, from the start offset and the beat index.
  function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] start,
                                                    input logic [BURST_W-1:0] beat,
                                                    input logic               ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic sel_ok,
  input  logic adv_ld,
  input  logic wr_n,
  output op_e  op_q,
  output logic load_evt,
  output logic adv_evt,
  output logic commit_en
);

  // Events of the current edge, exposed for the burst logic and the checker.
  assign load_evt  = !hold && !adv_ld && sel_ok;
  assign adv_evt   = !hold && adv_ld && (op_q != OP_IDLE);
  // A write beat takes its data at the next edge that is not held.
  assign commit_en = !hold && (op_q == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_IDLE;
    end else if (!hold && !adv_ld) begin
      op_q <= sel_ok ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
    end
    // advance edges and held edges keep the current operation
  end

endmodule

// File: rtl/ntsram_burst.sv
module ntsram_burst
  import ntsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_evt,
  input  logic          adv_evt,
  input  logic          ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_evt) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (adv_evt) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign cur_addr = {base_q[AW-1:BURST_W],
                     burst_step(base_q[BURST_W-1:0], beat_q, ilv)};

endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] be_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lane_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{!be_n[g]}};
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= (mem[addr] & ~lane_mask) | (wdata & lane_mask);
    end
  end

  // Flow-through read port.
  assign rdata = mem[addr];

endmodule

// File: rtl/ntsram_ft.sv
module ntsram_ft
  import ntsram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adv_ld,
  input  logic             wr_n,
  input  logic [LANES-1:0] be_n,
  input  logic             oe_n,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);

  op_e           op_q;
  logic          sel_ok;
  logic          load_evt;
  logic          adv_evt;
  logic          commit_en;
  logic [AW-1:0] cur_addr;

  assign sel_ok = sel_all(sel_a_n, sel_b, sel_c_n);

  ntsram_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .sel_ok    (sel_ok),
    .adv_ld    (adv_ld),
    .wr_n      (wr_n),
    .op_q      (op_q),
    .load_evt  (load_evt),
    .adv_evt   (adv_evt),
    .commit_en (commit_en)
  );

  ntsram_burst #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .adv_evt  (adv_evt),
    .ilv      (burst_ilv),
    .addr_in  (addr),
    .cur_addr (cur_addr)
  );

  ntsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (commit_en),
    .addr  (cur_addr),
    .be_n  (be_n),
    .wdata (din),
    .rdata (dout)
  );

  // Output enable acts without a clock edge.
  assign dout_en = (op_q == OP_RD) && !oe_n;

endmodule

// File: rtl/ntsram_chk.sv
module ntsram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          adv_ld,
  input logic          wr_n,
  input logic          oe_n,
  input logic          dout_en,
  input logic [1:0]    op,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] cur_addr,
  input logic          load_evt
);

  localparam int BW = ntsram_pkg::BURST_W;

  logic sel_good;
  assign sel_good = !sel_a_n && sel_b && !sel_c_n;

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (op == 2'b00 && !dout_en));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(op) && $stable(cur_addr)));

  // R3
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !adv_ld && !sel_good) |=> (op == 2'b00));

  // R3
  cont_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv_ld && op == 2'b00) |=> (op == 2'b00));

  // R4
  rd_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_evt && wr_n) |=> (op == 2'b01 && cur_addr == $past(addr)));

  // R5
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !wr_n) |=> (op == 2'b10 && cur_addr == $past(addr)));

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  // R11
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 2'b01) |-> !dout_en);

  // R8
  burst_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && adv_ld && op != 2'b00) |=> (cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])));

endmodule

bind ntsram_ft ntsram_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .adv_ld   (adv_ld),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .dout_en  (dout_en),
  .op       (op_q),
  .addr     (addr),
  .cur_addr (cur_addr),
  .load_evt (load_evt)
);

// File: tb/ntsram_ft_test.sv
module ntsram_ft_test;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hold = 1'b0;
  logic          sel_a_n = 1'b1;
  logic          sel_b = 1'b1;
  logic          sel_c_n = 1'b0;
  logic          adv_ld = 1'b0;
  logic          wr_n = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic          oe_n = 1'b0;
  logic          burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  ntsram_ft uut (
    .clk(clk), .rst(rst), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv_ld(adv_ld), .wr_n(wr_n), .be_n(be_n), .oe_n(oe_n),
    .burst_ilv(burst_ilv), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change 1 ns after an edge; outputs are settled then as well.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_sel(input logic sa, input logic sb, input logic sc, input logic wrn,
                          input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] be);
    sel_a_n = sa; sel_b = sb; sel_c_n = sc;
    adv_ld = 1'b0; wr_n = wrn; addr = a; din = d; be_n = be;
    tick();
  endtask

  task automatic load(input logic wrn, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] be);
    load_sel(1'b0, 1'b1, 1'b0, wrn, a, d, be);
  endtask

  task automatic cont(input logic [DW-1:0] d, input logic [3:0] be);
    adv_ld = 1'b1; din = d; be_n = be; addr = 8'hEE; wr_n = ~wr_n;
    tick();
  endtask

  task automatic desel(input logic [DW-1:0] d, input logic [3:0] be);
    sel_a_n = 1'b1; adv_ld = 1'b0; din = d; be_n = be;
    tick();
  endtask

  task automatic write1(input logic [AW-1:0] a, input logic [DW-1:0] d);
    load(1'b0, a, 32'h0BAD_0BAD, 4'hF);
    desel(d, 4'h0);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    load(1'b1, a, '0, 4'hF);
    check(dout_en === 1'b1 && dout === exp, tag, dout, exp);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst = 1'b0;
    check(dout_en === 1'b0, "R1 no drive after reset", {31'd0, dout_en}, 32'd0);
    cont('0, 4'hF);
    check(dout_en === 1'b0, "R1 advance before any load", {31'd0, dout_en}, 32'd0);
  endtask

  task automatic t_read_write();
    write1(8'h10, 32'hA5A5_0001);
    read_chk(8'h10, 32'hA5A5_0001, "R4 flow-through read");
    load(1'b0, 8'h11, 32'hDEAD_BEEF, 4'h0);   // data at the command edge is ignored
    desel(32'h1234_5678, 4'h0);
    read_chk(8'h11, 32'h1234_5678, "R5 late write data");
  endtask

  task automatic t_bytes();
    write1(8'h20, 32'h1122_3344);
    load(1'b0, 8'h20, '0, 4'hF);
    desel(32'hAABB_CCDD, 4'b1010);
    read_chk(8'h20, 32'h11BB_33DD, "R6 byte lanes 0 and 2");
    write1(8'h24, 32'h0);
    write1(8'h25, 32'h0);
    burst_ilv = 1'b0;
    load(1'b0, 8'h24, '0, 4'hF);
    cont(32'hFFFF_FFFF, 4'hF);             // aborted beat, address 24
    desel(32'hCAFE_0025, 4'h0);            // beat for address 25
    read_chk(8'h24, 32'h0, "R6 aborted beat stores nothing");
    read_chk(8'h25, 32'hCAFE_0025, "R6 burst advances past abort");
  endtask

  task automatic t_linear();
    for (int i = 0; i < 4; i++) write1(8'h30 + 8'(i), 32'h5000_0030 + i);
    burst_ilv = 1'b0;
    load(1'b1, 8'h31, '0, 4'hF);
    check(dout === 32'h5000_0031, "R8 linear beat 0", dout, 32'h5000_0031);
    cont('0, 4'hF);
    check(dout === 32'h5000_0032, "R8 linear beat 1", dout, 32'h5000_0032);
    cont('0, 4'hF);
    check(dout === 32'h5000_0033, "R8 linear beat 2", dout, 32'h5000_0033);
    cont('0, 4'hF);
    check(dout === 32'h5000_0030, "R8 linear beat 3", dout, 32'h5000_0030);
    cont('0, 4'hF);
    check(dout_en === 1'b1 && dout === 32'h5000_0031, "R8 linear wrap", dout, 32'h5000_0031);
  endtask

  task automatic t_interleaved();
    burst_ilv = 1'b1;
    load(1'b1, 8'h31, '0, 4'hF);
    check(dout === 32'h5000_0031, "R9 interleaved beat 0", dout, 32'h5000_0031);
    cont('0, 4'hF);
    check(dout === 32'h5000_0030, "R9 interleaved beat 1", dout, 32'h5000_0030);
    cont('0, 4'hF);
    check(dout === 32'h5000_0033, "R9 interleaved beat 2", dout, 32'h5000_0033);
    cont('0, 4'hF);
    check(dout === 32'h5000_0032, "R9 interleaved beat 3", dout, 32'h5000_0032);
    burst_ilv = 1'b0;
  endtask

  task automatic t_dummy_oe();
    oe_n = 1'b1;
    load(1'b1, 8'h30, '0, 4'hF);
    check(dout_en === 1'b0, "R7 dummy read stays off", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b0;
    #1;
    check(dout_en === 1'b1 && dout === 32'h5000_0030, "R7 oe low drives at once", dout, 32'h5000_0030);
    oe_n = 1'b1;
    #1;
    check(dout_en === 1'b0, "R7 oe high releases at once", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b0;
  endtask

  task automatic t_selects();
    load_sel(1'b1, 1'b1, 1'b0, 1'b1, 8'h10, '0, 4'hF);
    check(dout_en === 1'b0, "R3 first select inactive", {31'd0, dout_en}, 32'd0);
    load_sel(1'b0, 1'b0, 1'b0, 1'b1, 8'h10, '0, 4'hF);
    check(dout_en === 1'b0, "R3 second select inactive", {31'd0, dout_en}, 32'd0);
    load_sel(1'b0, 1'b1, 1'b1, 1'b1, 8'h10, '0, 4'hF);
    check(dout_en === 1'b0, "R3 third select inactive", {31'd0, dout_en}, 32'd0);
    cont('0, 4'hF);
    check(dout_en === 1'b0, "R3 continue after deselect", {31'd0, dout_en}, 32'd0);
    load_sel(1'b0, 1'b0, 1'b0, 1'b0, 8'h10, '0, 4'hF);
    desel(32'hFFFF_FFFF, 4'h0);
    read_chk(8'h10, 32'hA5A5_0001, "R3 deselected write stores nothing");
  endtask

  task automatic t_hold();
    read_chk(8'h10, 32'hA5A5_0001, "R2 read before hold");
    hold = 1'b1;
    load(1'b1, 8'h11, '0, 4'hF);
    check(dout_en === 1'b1 && dout === 32'hA5A5_0001, "R2 held edge keeps read", dout, 32'hA5A5_0001);
    hold = 1'b0;
    load(1'b0, 8'h40, '0, 4'hF);
    hold = 1'b1;
    desel(32'h0000_0BAD, 4'h0);
    hold = 1'b0;
    desel(32'h4040_4040, 4'h0);
    read_chk(8'h40, 32'h4040_4040, "R2 pending write waits for unheld edge");
  endtask

  task automatic t_no_turn();
    write1(8'h50, 32'h0);
    load(1'b1, 8'h10, '0, 4'hF);
    check(dout_en === 1'b1 && dout === 32'hA5A5_0001, "R10 read in mixed stream", dout, 32'hA5A5_0001);
    load(1'b0, 8'h50, '0, 4'hF);
    check(dout_en === 1'b0, "R11 no drive in write cycle", {31'd0, dout_en}, 32'd0);
    load(1'b1, 8'h50, 32'h5050_AAAA, 4'h0);
    check(dout_en === 1'b1 && dout === 32'h5050_AAAA, "R10 read right after write", dout, 32'h5050_AAAA);
    desel('0, 4'hF);
    check(dout_en === 1'b0, "R11 no drive when deselected", {31'd0, dout_en}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_read_write();
    t_bytes();
    t_linear();
    t_interleaved();
    t_dummy_oe();
    t_selects();
    t_hold();
    t_no_turn();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule